// File: doc/BRIEF.md
# Triggered DMA Channel

This block is one DMA channel. A processor-side write port loads four registers: a source address, a destination address, a unit count and a 16-bit control word. Setting the enable bit in the control word arms the channel. After a fixed two-cycle delay the channel either starts at once or waits for the start event selected in the control word. The start event can be a vertical-blank pulse, a horizontal-blank pulse or a display-synchronised special request.

Once started, the channel moves the programmed number of units over a simple memory master port. Each unit is one read cycle followed by one write cycle, and each unit is 16 or 32 bits wide. The channel steps working copies of the two addresses by their own modes. The programmed register values are never changed, so a re-armed, repeated or reloading transfer restarts from them. At the end of a block the channel can pulse an interrupt. In repeat mode it can re-arm itself for the next start event.

The memory port has fixed timing. Read data must be valid in the cycle after the read request, and it is forwarded unchanged as write data.

Top module: `dma_channel`

## Requirements
- R1: After reset the control word reads 0000h, and `mem_req` and `irq` are low.
- R2: Control word fields: [6:5] destination mode, [8:7] source mode, [9] repeat, [10] unit width, [13:12] start event, [14] interrupt enable, [15] enable. When a write sets bit 15 while it was 0, no memory request appears in the next two cycles. With immediate start (00), the first read is issued in the third cycle.
- R3: Each unit is a read of the working source address (`mem_we`=0) followed in the next cycle by a write to the working destination address (`mem_we`=1). The write data is the read data returned in that cycle. For 16-bit units only the low half is forwarded and the upper half is zero. `mem_wide` shows the width (1 = 32-bit).
- R4: Source mode 00 adds the unit size (2 bytes for width 0, 4 bytes for width 1) after each unit, 01 subtracts it, and 10 holds the address. Code 11 is not valid for the source and also holds the address.
- R5: Destination modes 00, 01 and 10 behave as for the source. Mode 11 adds the unit size after each unit and restores the programmed destination at the end of the block.
- R6: Start event codes are 00 immediate, 01 `trig_vblank`, 10 `trig_hblank` and 11 `trig_special`. While waiting, the channel starts only on the selected input and ignores the other two.
- R7: A programmed count of zero moves 2^CW units (16384 by default).
- R8: With repeat at 0, or with immediate start, the enable bit clears after the last unit. With repeat at 1 and a triggered start, the enable bit stays set and the count reloads. The source address continues from where it stopped, and the channel waits for the next event.
- R9: `irq` pulses for one cycle right after the last write of a block, and only when interrupt enable is 1.
- R10: Writing the control word with bit 15 at 0 disarms the channel. Later start events then cause no memory request.
- R11: Every arming starts from the programmed source and destination registers, whatever addresses the previous transfer ended at.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | 32 | Register write data |
| ctrl_rd | output | 16 | Current control word |
| trig_vblank | input | 1 | Vertical-blank start event |
| trig_hblank | input | 1 | Horizontal-blank start event |
| trig_special | input | 1 | Display-synchronised special start request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wide | output | 1 | 1 = 32-bit unit, 0 = 16-bit unit |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| irq | output | 1 | Block-complete interrupt pulse |

## Verification
The assertions check four things on every cycle:
- the two idle cycles after arming;
- the strict pairing of each read with a write in the next cycle;
- that a fixed source address never moves;
- that no request or interrupt appears outside a transfer, and that an interrupt only follows a write.

Only the bench scenarios can show the following:
- the exact address sequences for every pair of source and destination modes at both widths;
- the reload of the destination and the continued source across repeated blocks;
- which start input each timing code responds to;
- the 16384-unit block that a zero count produces.

// File: rtl/dma_channel.sv
module dma_channel #(
  parameter int AW = 32,
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic [15:0]   ctrl_rd,
  input  logic          trig_vblank,
  input  logic          trig_hblank,
  input  logic          trig_special,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_wide,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          irq
);
  localparam int CNTW = CW + 1;
  localparam logic [CNTW-1:0] FULL = {1'b1, {CW{1'b0}}};

  typedef enum logic [2:0] {S_IDLE, S_DLY1, S_DLY2, S_WAIT, S_RD, S_WR} st_t;
  st_t st;

  logic [AW-1:0]   src_r, dst_r, src_w, dst_w;
  logic [CW-1:0]   cnt_r;
  logic [CNTW-1:0] left;
  logic [15:0]     ctrl;

  wire [1:0] dmode = ctrl[6:5];
  wire [1:0] smode = ctrl[8:7];
  wire [1:0] tmode = ctrl[13:12];
  wire rpt  = ctrl[9];
  wire wide = ctrl[10];
  wire ien  = ctrl[14];
  wire en   = ctrl[15];

  wire ctl_wr = cfg_we && (cfg_sel == 2'd3);
  wire arm    = ctl_wr && cfg_wdata[15] && !en;
  wire disarm = ctl_wr && !cfg_wdata[15];

  wire [AW-1:0]   step   = wide ? AW'(4) : AW'(2);
  wire            last   = (left == CNTW'(1));
  wire [CNTW-1:0] reload = (cnt_r == '0) ? FULL : {1'b0, cnt_r};
  wire fired = (tmode == 2'd1) ? trig_vblank :
               (tmode == 2'd2) ? trig_hblank :
               (tmode == 2'd3) ? trig_special : 1'b1;

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a, input logic [1:0] m);
    case (m)
      2'b00, 2'b11: step_addr = a + step;
      2'b01:        step_addr = a - step;
      default:      step_addr = a;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      src_r <= '0;
      dst_r <= '0;
      src_w <= '0;
      dst_w <= '0;
      cnt_r <= '0;
      left  <= '0;
      ctrl  <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (st)
        S_DLY1: st <= S_DLY2;
        S_DLY2: st <= (tmode == 2'd0) ? S_RD : S_WAIT;
        S_WAIT: if (fired) st <= S_RD;
        S_RD:   st <= S_WR;
        S_WR: begin
          src_w <= (smode == 2'b11) ? src_w : step_addr(src_w, smode);
          dst_w <= step_addr(dst_w, dmode);
          left  <= left - CNTW'(1);
          if (last) begin
            irq <= ien;
            if (dmode == 2'b11) dst_w <= dst_r;
            if (rpt && tmode != 2'd0) begin
              left <= reload;
              st   <= S_WAIT;
            end else begin
              st       <= S_IDLE;
              ctrl[15] <= 1'b0;
            end
          end else begin
            st <= S_RD;
          end
        end
        default: ;
      endcase
      if (arm) begin
        st    <= S_DLY1;
        src_w <= src_r;
        dst_w <= dst_r;
        left  <= reload;
      end else if (disarm) begin
        st <= S_IDLE;
      end
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: src_r <= cfg_wdata[AW-1:0];
          2'd1: dst_r <= cfg_wdata[AW-1:0];
          2'd2: cnt_r <= cfg_wdata[CW-1:0];
          default: ctrl <= cfg_wdata[15:0];
        endcase
      end
    end
  end

  assign ctrl_rd   = ctrl;
  assign mem_req   = (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_wide  = wide;
  assign mem_addr  = (st == S_WR) ? dst_w : src_w;
  assign mem_wdata = wide ? mem_rdata : {16'h0000, mem_rdata[15:0]};

  p_arm_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !mem_req ##1 !mem_req);

  p_rd_then_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && !disarm) |=> (mem_req && mem_we));

  p_wr_after_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> $past(mem_req && !mem_we));

  p_src_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && smode == 2'b10) |=> $stable(src_w));

  p_irq_after_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(mem_req && mem_we));

  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !mem_req);
endmodule

// File: tb/dma_channel_test.sv
`timescale 1ns/1ps
module dma_channel_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [15:0] ctrl_rd;
  logic trig_vblank = 1'b0, trig_hblank = 1'b0, trig_special = 1'b0;
  logic mem_req, mem_we, mem_wide, irq;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  always #5 clk = ~clk;

  dma_channel uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ctrl_rd(ctrl_rd), .trig_vblank(trig_vblank), .trig_hblank(trig_hblank),
    .trig_special(trig_special), .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {~a[15:0], a[15:0] ^ 16'h1234};
  endfunction

  always @(posedge clk) if (mem_req && !mem_we) mem_rdata <= pat(mem_addr);

  typedef struct { logic [31:0] ra; logic [31:0] wa; logic wide; string tag; } item_t;
  item_t q[$];
  int vectors = 0, fails = 0, irq_cnt = 0;
  logic [31:0] last_ra = '0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (irq) irq_cnt++;
    if (mem_req && !mem_we) last_ra = mem_addr;
    if (mem_req && mem_we) begin
      if (q.size() == 0) chk(0, "R3 unexpected write", mem_addr, 32'h0);
      else begin
        item_t e;
        logic [31:0] ed;
        e = q.pop_front();
        ed = e.wide ? pat(e.ra) : {16'h0, pat(e.ra)[15:0]};
        chk(last_ra == e.ra, {e.tag, " read address"}, last_ra, e.ra);
        chk(mem_addr == e.wa, {e.tag, " write address"}, mem_addr, e.wa);
        chk(mem_wdata == ed && mem_wide == e.wide, {e.tag, " R3 write data"}, mem_wdata, ed);
      end
    end
  end

  function automatic logic [15:0] mk(input bit en, input bit ien, input logic [1:0] tm,
      input bit wide, input bit rpt, input logic [1:0] sm, input logic [1:0] dm);
    return {en, ien, tm, 1'b0, wide, rpt, sm, dm, 5'b0};
  endfunction

  task automatic expect_block(inout logic [31:0] s, inout logic [31:0] d, input int n,
      input logic [1:0] sm, input logic [1:0] dm, input bit wide, input logic [31:0] dbase,
      input string tag);
    logic [31:0] st;
    st = wide ? 32'd4 : 32'd2;
    for (int i = 0; i < n; i++) begin
      item_t e;
      e.ra = s; e.wa = d; e.wide = wide; e.tag = tag;
      q.push_back(e);
      if (sm == 2'b00) s = s + st; else if (sm == 2'b01) s = s - st;
      if (dm == 2'b00 || dm == 2'b11) d = d + st; else if (dm == 2'b01) d = d - st;
    end
    if (dm == 2'b11) d = dbase;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    trig_vblank = (which == 1); trig_hblank = (which == 2); trig_special = (which == 3);
    @(negedge clk);
    trig_vblank = 0; trig_hblank = 0; trig_special = 0;
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while (q.size() != 0 && n < 40000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    chk(q.size() == 0, {tag, " all units done"}, q.size(), 0);
  endtask

  task automatic quiet(input int cycles, input string tag);
    bit seen = 0;
    for (int i = 0; i < cycles; i++) begin @(negedge clk); if (mem_req) seen = 1; end
    chk(!seen, tag, seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] s, d;
    int base_irq;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctrl_rd == 16'h0000 && !mem_req && !irq, "R1 reset state", {ctrl_rd, 14'b0, mem_req, irq}, 0);

    // R2 arming delay, R9 irq, R8 self clear
    wr(0, 32'h0000_1000); wr(1, 32'h0000_2000); wr(2, 4);
    s = 32'h1000; d = 32'h2000;
    expect_block(s, d, 4, 2'b00, 2'b00, 0, 32'h2000, "R2/R4");
    base_irq = irq_cnt;
    @(negedge clk); cfg_we = 1; cfg_sel = 3; cfg_wdata = {16'h0, mk(1,1,0,0,0,0,0)};
    @(negedge clk); cfg_we = 0;
    chk(!mem_req, "R2 idle cycle 1", mem_req, 0);
    @(negedge clk); chk(!mem_req, "R2 idle cycle 2", mem_req, 0);
    @(negedge clk); chk(mem_req && !mem_we, "R2 first read in third cycle", mem_req, 1);
    drain("R2");
    chk(ctrl_rd[15] == 0, "R8 enable clears", ctrl_rd[15], 0);
    chk(irq_cnt == base_irq + 1, "R9 one irq", irq_cnt, base_irq + 1);

    // R11 re-arm from programmed registers
    s = 32'h1000; d = 32'h2000;
    expect_block(s, d, 4, 2'b00, 2'b00, 0, 32'h2000, "R11");
    wr(3, {16'h0, mk(1,1,0,0,0,0,0)});
    drain("R11");

    // R4 R5 every mode pair, both widths, no irq
    base_irq = irq_cnt;
    for (int w = 0; w < 2; w++)
      for (int sm = 0; sm < 4; sm++)
        for (int dm = 0; dm < 4; dm++) begin
          wr(0, 32'h0000_4100); wr(1, 32'h0000_8200); wr(2, 3);
          s = 32'h4100; d = 32'h8200;
          expect_block(s, d, 3, 2'(sm), 2'(dm), w[0], 32'h8200, "R4/R5");
          wr(3, {16'h0, mk(1,0,0,w[0],0,2'(sm),2'(dm))});
          drain("R4/R5");
        end
    chk(irq_cnt == base_irq, "R9 no irq when disabled", irq_cnt, base_irq);

    // R6 R8 vblank repeat, 32-bit, dst reload, src continues
    wr(0, 32'h0000_3000); wr(1, 32'h0000_6000); wr(2, 2);
    wr(3, {16'h0, mk(1,1,1,1,1,0,3)});
    base_irq = irq_cnt;
    quiet(8, "R6 waits for event");
    pulse(2); quiet(4, "R6 hblank ignored");
    pulse(3); quiet(4, "R6 special ignored");
    s = 32'h3000; d = 32'h6000;
    expect_block(s, d, 2, 2'b00, 2'b11, 1, 32'h6000, "R6/R5");
    pulse(1); drain("R6");
    chk(ctrl_rd[15] == 1, "R8 repeat stays armed", ctrl_rd[15], 1);
    expect_block(s, d, 2, 2'b00, 2'b11, 1, 32'h6000, "R8 repeat");
    pulse(1); drain("R8");
    chk(irq_cnt == base_irq + 2, "R9 irq per block", irq_cnt, base_irq + 2);

    // R10 disarm
    wr(3, {16'h0, mk(0,1,1,1,1,0,3)});
    pulse(1); quiet(6, "R10 disarmed ignores event");

    // R6 hblank and special starts
    wr(0, 32'h0000_5000); wr(1, 32'h0000_7000); wr(2, 2);
    wr(3, {16'h0, mk(1,0,2,0,0,1,1)});
    s = 32'h5000; d = 32'h7000;
    expect_block(s, d, 2, 2'b01, 2'b01, 0, 32'h7000, "R6 hblank");
    repeat (3) @(negedge clk);
    pulse(1); quiet(4, "R6 vblank ignored");
    pulse(2); drain("R6 hblank");
    wr(3, {16'h0, mk(1,0,3,1,0,2,0)});
    s = 32'h5000; d = 32'h7000;
    expect_block(s, d, 2, 2'b10, 2'b00, 1, 32'h7000, "R6 special");
    repeat (3) @(negedge clk);
    pulse(3); drain("R6 special");

    // R8 repeat with immediate start is single
    wr(3, {16'h0, mk(1,0,0,0,1,0,0)});
    s = 32'h5000; d = 32'h7000;
    expect_block(s, d, 2, 2'b00, 2'b00, 0, 32'h7000, "R8 immediate");
    drain("R8 immediate");
    chk(ctrl_rd[15] == 0, "R8 immediate repeat single", ctrl_rd[15], 0);

    // R7 zero count
    wr(0, 32'h0000_0100); wr(1, 32'h0001_0000); wr(2, 0);
    s = 32'h0100; d = 32'h0001_0000;
    expect_block(s, d, 16384, 2'b10, 2'b00, 0, 32'h0001_0000, "R7");
    wr(3, {16'h0, mk(1,0,0,0,0,2,0)});
    drain("R7");
    chk(ctrl_rd[15] == 0, "R7 block ended", ctrl_rd[15], 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule